// File: doc/BRIEF.md
# Count/Compare Timer with Routed Interrupt

This block keeps a 32-bit up-counter that advances by one on each tick-enable pulse. It also holds a 32-bit compare value. When a tick brings the counter to the compare value, the block raises a timer interrupt. The interrupt drives one of eight interrupt lines, chosen by a 3-bit selector. When the release-2 mode bit is set, the match also sets a status bit that software can read.

Software can load the counter and the compare value directly. A load of the compare value is how software acknowledges the interrupt: it clears both the status bit and the interrupt line. A count-disable control freezes the counter. Because no tick can advance the counter while it is frozen, no match, and therefore no interrupt, can occur in that time. Decoding of the register bus, the interrupt controller and exception handling all sit outside this block.

Top module: `tmr_cmp_timer`

## Requirements
- R1: After a synchronous active-low reset the counter reads 1, the compare value is 0, the status bit is 0 and all eight lines are 0.
- R2: With the disable input low and no counter load, each cycle with `tick_en` high increments the counter by one, visible on the next cycle.
- R3: While `cnt_disable` is high the counter holds its value under ticks, but a counter load is still taken.
- R4: A counter load and a tick in the same cycle leave the loaded value in the counter.
- R5: The counter wraps from 0xFFFFFFFF to 0 on a tick, with no effect beyond the normal match rule.
- R6: A tick that makes the counter equal to the compare value sets an internal pending flag. One cycle later, line `line_sel` (bit index = selector value) goes high and every other line stays low. A counter load that makes the counter equal to the compare value raises nothing.
- R7: A match sets `ti_status` on the following cycle only if `r2_mode` is high in the match cycle. Otherwise the status bit stays 0, while the line is still driven.
- R8: A compare load clears `ti_status` on the next cycle and drops the lines one cycle after that. A compare load in the same cycle as a match wins, so nothing is raised.
- R9: While `cnt_disable` is high no interrupt is raised, whatever the tick input does.
- R10: While the interrupt is pending, a change of `line_sel` moves the asserted line to the new index on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advance the counter by one this cycle |
| cnt_wr_en | input | 1 | Load the counter this cycle |
| cnt_wr_data | input | 32 | Value to load into the counter |
| cmp_wr_en | input | 1 | Load the compare value this cycle (also acknowledges the interrupt) |
| cmp_wr_data | input | 32 | Compare value to load |
| cnt_disable | input | 1 | Freeze the counter and block interrupts |
| r2_mode | input | 1 | Enable the timer status bit |
| line_sel | input | 3 | Index of the interrupt line to drive |
| count_val | output | 32 | Current counter value |
| ti_status | output | 1 | Timer-interrupt status bit |
| irq_lines | output | 8 | One-hot interrupt line vector |

## Verification
The bench checks the wrap from all-ones to zero against the reset compare value of 0. A design that treated the wrap specially, or reset the compare value wrongly, would miss that interrupt or raise a stray one. It targets the same-cycle collisions: a counter load against a tick, and a compare load against a match. Getting either wrong leaves an off-by-one count or a stuck interrupt. It also checks that the counter freezes under the disable input while loads still land, that the status bit stays silent outside release-2 mode, and that the line follows a selector change. A faulty router would leave a stale line high or drive two lines at once.

// File: rtl/tmr_pkg.sv
// Shared sizing for the count/compare timer.
// Assumes: one clock domain and a synchronous active-low reset everywhere.
package tmr_pkg;
    localparam int CNT_W     = 32;
    localparam int LINES     = 8;
    localparam int SEL_W     = $clog2(LINES);
    localparam logic [CNT_W-1:0] CNT_RESET = CNT_W'(1);
    localparam logic [CNT_W-1:0] CMP_RESET = '0;
endpackage

// File: rtl/tmr_counter.sv
// Up-counter with a direct load, a tick enable and a freeze control.
// A load takes precedence over a tick, and a load is honoured while frozen.
// Assumes the tick is a single-cycle qualifier sampled on the clock.
module tmr_counter #(
    parameter int W = 32,
    parameter logic [W-1:0] RST_VAL = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         freeze,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] count_q,
    output logic [W-1:0] count_inc,
    output logic         advance
);
    // Counter advances only on an unfrozen tick that is not overridden by a load
    always_comb begin
        advance   = tick_en && !freeze && !ld_en;
        count_inc = count_q + W'(1);
    end

    // Counter register: reset, load, or increment
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= RST_VAL;
        else if (ld_en)   count_q <= ld_val;
        else if (advance) count_q <= count_inc;
    end

    // R3
    // cnt_hold_chk
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !ld_en) |=> $stable(count_q));

    // R4
    // cnt_load_chk
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (count_q == $past(ld_val)));
endmodule

// File: rtl/tmr_match_irq.sv
// Holds the compare value and the interrupt state.
// A match is a tick that makes the counter equal to compare. It sets the
// pending flag, and also the status bit when release-2 mode is on.
// A compare load clears both and outranks a same-cycle match.
module tmr_match_irq #(
    parameter int W = 32,
    parameter logic [W-1:0] CMP_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic [W-1:0] count_inc,
    input  logic         cmp_ld,
    input  logic [W-1:0] cmp_val,
    input  logic         r2_mode,
    input  logic         freeze,
    output logic         pending_q,
    output logic         status_q
);
    logic [W-1:0] cmp_q;
    logic         hit;

    // Match only when the counter is really stepping onto the compare value
    always_comb hit = advance && (count_inc == cmp_q);

    // Compare register
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= CMP_RST;
        else if (cmp_ld) cmp_q <= cmp_val;
    end

    // Pending flag and mode-gated status bit; a compare load acknowledges both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            status_q  <= 1'b0;
        end else if (cmp_ld) begin
            pending_q <= 1'b0;
            status_q  <= 1'b0;
        end else if (hit) begin
            pending_q <= 1'b1;
            status_q  <= status_q | r2_mode;
        end
    end

    // R8
    // ack_clear_chk
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_ld |=> (!pending_q && !status_q));

    // R7
    // status_mode_chk
    status_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q && !r2_mode) |=> !status_q);

    // R9
    // frozen_quiet_chk
    frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !pending_q) |=> !pending_q);
endmodule

// File: rtl/tmr_line_router.sv
// Registers the pending flag onto the line picked by the selector.
// Assumes the selector may change at any time; the output follows it
// one cycle later.
module tmr_line_router #(
    parameter int N  = 8,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pending,
    input  logic [SW-1:0] sel,
    output logic [N-1:0]  lines_q
);
    // One flop per line, each decoding its own index
    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) lines_q[i] <= 1'b0;
            else        lines_q[i] <= pending && (sel == SW'(i));
        end
    end

    // R6
    // line_onehot_chk
    line_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lines_q));

    // R10
    // line_follow_chk
    line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> (lines_q == (N'(1) << $past(sel))));
endmodule

// File: rtl/tmr_cmp_timer.sv
// Top of the count/compare timer: counter, match/acknowledge logic and
// line router. Assumes all controls are synchronous to clk.
module tmr_cmp_timer
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    input  logic             cnt_disable,
    input  logic             r2_mode,
    input  logic [SEL_W-1:0] line_sel,
    output logic [CNT_W-1:0] count_val,
    output logic             ti_status,
    output logic [LINES-1:0] irq_lines
);
    logic [CNT_W-1:0] inc;
    logic             adv;
    logic             pend;

    tmr_counter #(.W(CNT_W), .RST_VAL(CNT_RESET)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(cnt_disable),
        .ld_en(cnt_wr_en), .ld_val(cnt_wr_data),
        .count_q(count_val), .count_inc(inc), .advance(adv)
    );

    tmr_match_irq #(.W(CNT_W), .CMP_RST(CMP_RESET)) u_irq (
        .clk(clk), .rst_n(rst_n), .advance(adv), .count_inc(inc),
        .cmp_ld(cmp_wr_en), .cmp_val(cmp_wr_data), .r2_mode(r2_mode),
        .freeze(cnt_disable), .pending_q(pend), .status_q(ti_status)
    );

    tmr_line_router #(.N(LINES), .SW(SEL_W)) u_route (
        .clk(clk), .rst_n(rst_n), .pending(pend), .sel(line_sel),
        .lines_q(irq_lines)
    );
endmodule

// File: tb/tmr_cmp_timer_bench.sv
`timescale 1ns/1ps
module tmr_cmp_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, cnt_wr_en = 1'b0, cmp_wr_en = 1'b0;
    logic [31:0] cnt_wr_data = '0, cmp_wr_data = '0;
    logic        cnt_disable = 1'b0, r2_mode = 1'b0;
    logic [2:0]  line_sel = '0;
    logic [31:0] count_val;
    logic        ti_status;
    logic [7:0]  irq_lines;

    int checks = 0, errors = 0;
    bit chk_on = 1'b0, done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    longint m_cnt, m_cmp;
    bit     m_pend, m_ti;
    int     m_lines;

    always #2 clk = ~clk;

    tmr_cmp_timer u_tmr_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr_en(cnt_wr_en),
        .cnt_wr_data(cnt_wr_data), .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .cnt_disable(cnt_disable), .r2_mode(r2_mode), .line_sel(line_sel),
        .count_val(count_val), .ti_status(ti_status), .irq_lines(irq_lines)
    );

    task automatic chk(string req, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got=%0h exp=%0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // model update at each active edge
    always @(posedge clk) begin
        int nl;
        bit match;
        nl = m_pend ? (1 << line_sel) : 0;
        if (!rst_n) begin
            m_cnt = 1; m_cmp = 0; m_pend = 0; m_ti = 0; nl = 0;
        end else begin
            match = tick_en && !cnt_disable && !cnt_wr_en &&
                    (((m_cnt + 1) % 64'h1_0000_0000) == m_cmp);
            if (cmp_wr_en) begin m_pend = 0; m_ti = 0; end
            else if (match) begin m_pend = 1; if (r2_mode) m_ti = 1; end
            if (cnt_wr_en) m_cnt = cnt_wr_data;
            else if (tick_en && !cnt_disable) m_cnt = (m_cnt + 1) % 64'h1_0000_0000;
            if (cmp_wr_en) m_cmp = cmp_wr_data;
        end
        m_lines = nl;
    end

    // compare with model every cycle, away from the active edge
    always @(negedge clk) if (chk_on) begin
        chk(cur_req, "count_val", count_val, m_cnt);
        chk(cur_req, "ti_status", ti_status, m_ti);
        chk(cur_req, "irq_lines", irq_lines, m_lines);
    end

    // advance one cycle and drop single-cycle write strobes
    task automatic nxt();
        @(negedge clk); #1;
        cnt_wr_en = 1'b0; cmp_wr_en = 1'b0;
    endtask

    task automatic ldc(logic [31:0] v); cnt_wr_en = 1'b1; cnt_wr_data = v; endtask
    task automatic ldp(logic [31:0] v); cmp_wr_en = 1'b1; cmp_wr_data = v; endtask

    initial begin
        repeat (3) nxt();
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R1 reset state
        chk("R1", "reset count", count_val, 1);
        chk("R1", "reset status", ti_status, 0);
        chk("R1", "reset lines", irq_lines, 0);

        // R2 five ticks
        cur_req = "R2"; tick_en = 1'b1;
        repeat (5) nxt();
        tick_en = 1'b0;
        chk("R2", "count after 5 ticks", count_val, 6);

        // R5 wrap onto reset compare of 0 (R1)
        cur_req = "R5"; r2_mode = 1'b1; line_sel = 3'd3;
        ldc(32'hFFFF_FFFE); nxt();
        tick_en = 1'b1; nxt();
        chk("R5", "count before wrap", count_val, 32'hFFFF_FFFF);
        nxt(); tick_en = 1'b0;
        chk("R5", "count after wrap", count_val, 0);
        chk("R1", "match on reset compare 0", ti_status, 1);
        chk("R6", "line lags pending", irq_lines, 0);
        nxt();
        chk("R6", "line 3 asserted", irq_lines, 8'h08);

        // R10 selector move
        cur_req = "R10"; line_sel = 3'd5; nxt();
        chk("R10", "line moved to 5", irq_lines, 8'h20);

        // R8 acknowledge
        cur_req = "R8"; ldp(100); nxt();
        chk("R8", "status cleared", ti_status, 0);
        nxt();
        chk("R8", "lines cleared", irq_lines, 0);

        // R7 no status outside release-2 mode
        cur_req = "R7"; r2_mode = 1'b0;
        ldc(98); nxt();
        tick_en = 1'b1; nxt(); nxt(); tick_en = 1'b0;
        chk("R7", "status silent", ti_status, 0);
        nxt();
        chk("R7", "line still driven", irq_lines, 8'h20);
        ldp(200); nxt(); nxt();

        // R3 / R9 frozen counter
        cur_req = "R9"; r2_mode = 1'b1; cnt_disable = 1'b1; tick_en = 1'b1;
        ldc(199); nxt();
        chk("R3", "load while frozen", count_val, 199);
        repeat (4) nxt();
        chk("R3", "frozen count holds", count_val, 199);
        chk("R9", "no status while frozen", ti_status, 0);
        chk("R9", "no line while frozen", irq_lines, 0);
        ldc(150); nxt();
        chk("R3", "second frozen load", count_val, 150);

        // R4 load beats tick
        cur_req = "R4"; cnt_disable = 1'b0;
        ldc(1000); nxt(); tick_en = 1'b0;
        chk("R4", "load wins over tick", count_val, 1000);

        // R8 compare load beats same-cycle match
        cur_req = "R8"; ldp(300); nxt();
        ldc(299); nxt();
        tick_en = 1'b1; ldp(500); nxt(); tick_en = 1'b0;
        chk("R8", "count stepped to 300", count_val, 300);
        chk("R8", "collision status", ti_status, 0);
        nxt();
        chk("R8", "collision lines", irq_lines, 0);

        // R6 a load equal to compare raises nothing
        cur_req = "R6"; ldc(500); nxt(); nxt();
        chk("R6", "load-equal status", ti_status, 0);
        chk("R6", "load-equal lines", irq_lines, 0);

        // mixed traffic compared against the model each cycle
        for (int i = 0; i < 3000; i++) begin
            tick_en     = ($urandom % 4) != 0;
            cnt_disable = ($urandom % 16) == 0;
            r2_mode     = ($urandom % 3) != 0;
            if ($urandom % 40 == 0) line_sel = 3'($urandom);
            if (i % 37 == 0) ldp(count_val + 32'($urandom % 6) + 1);
            if ($urandom % 97 == 0) ldc(32'hFFFF_FFF0 + 32'($urandom % 16));
            nxt();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule